// File: doc/BRIEF.md
# External Interrupt Request Flag Unit

This block is the front end for eight external interrupt request pins. Every pin goes through a synchronizer. A detector then watches the pin for the condition its channel is set to sense: a low level, a falling edge, a rising edge, or either edge. When that condition occurs, the detector sets the channel's status flag. A flag stays set until something clears it, and a flag becomes a request to the processor only when its channel is enabled.

There are three ways to clear a flag. Software can clear it by writing 0 to the flag bit, but only after it has read that bit as 1. The processor clears it by acknowledging the channel's interrupt. A data-transfer engine clears it when the request starts a transfer and the keep input is low. An acknowledge in level mode clears the flag only if the synchronized pin is already high. Setting takes priority over every clear, so an event that arrives while a clear is in progress is not lost. Priority arbitration, vector generation and the transfer engine itself are outside this block.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous reset, all status flags, enable bits and request outputs are 0, and every sense code is 00.
- R2: The register map is: address 0 holds the flags (bit n is channel n), address 1 holds the enables, address 2 holds the sense codes of channels 3..0 and address 3 holds those of channels 7..4. Channel n uses the 2-bit field at bit 2*(n mod 4) of its sense register. The enable and sense registers read back the value that was written, and read data is combinational from the address.
- R3: The sense code selects the detection mode. Code 01 sets the flag on a falling edge, 10 on a rising edge and 11 on either edge. An edge that the mode does not select leaves the flag unchanged.
- R4: In sense code 00 the flag is set while the synchronized pin is low. The flag stays set after the pin returns high.
- R5: Writing 1 to a flag bit at address 0 never changes that flag.
- R6: Writing 0 to a flag bit clears the flag only if a read of address 0 returned 1 for that bit since the last write to address 0. Any write to address 0 cancels every earlier read qualification.
- R7: An acknowledge pulse on a channel in sense code 00 clears its flag only if the synchronized pin is high. If the pin is low, the flag stays set.
- R8: An acknowledge pulse on a channel in any edge mode clears its flag at the next clock edge.
- R9: A transfer-start pulse on a channel clears its flag when the keep input is 0 and leaves the flag set when the keep input is 1.
- R10: When a set condition and a clear condition occur in the same cycle, the flag ends up set.
- R11: Each request output equals the channel's flag ANDed with its enable bit. A disabled flag remains readable at address 0.
- R12: A pin change reaches the flag on the third rising clock edge after it: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms clear qualification on address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_pin | input | 8 | Raw asynchronous request pins |
| irq_ack | input | 8 | Per-channel acknowledge strobes |
| xfer_start | input | 8 | Per-channel transfer-start strobes |
| xfer_keep | input | 1 | When 1, a transfer start keeps the flag |
| irq_req | output | 8 | Per-channel request outputs |

## Verification
The assertions are checked on every cycle. They cover these behaviours:
- A disabled channel never drives its request output.
- A status write of all ones never drops a flag.
- A flag only falls in a cycle that carries an acknowledge, a transfer start or a status write.
- A detected event always leaves its flag set.
- An acknowledge in an edge mode always clears the flag.

Some behaviours can only be shown by the bench's scenarios:
- The read-then-write handshake, including its cancellation by an intervening write.
- The level-mode acknowledge that depends on the pin.
- The keep input on a transfer start.
- The exact three-edge latency from pin to flag.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] A_SENSE0 = 2'd2;
    localparam logic [ADDR_W-1:0] A_SENSE1 = 2'd3;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic rd_flags;
        logic wr_flags;
    } bus_evt_t;

    typedef struct packed {
        logic set;
        logic ack;
        logic xfer;
        logic sw;
    } flag_evt_t;

    function automatic logic sense_hit(sense_e mode, logic cur, logic prv);
        logic hit;
        unique case (mode)
            SENSE_LOW:  hit = ~cur;
            SENSE_FALL: hit = prv & ~cur;
            SENSE_RISE: hit = ~prv & cur;
            SENSE_BOTH: hit = prv ^ cur;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic is_level(sense_e mode);
        return mode == SENSE_LOW;
    endfunction

endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int NCH    = 8,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin_raw,
    output logic [NCH-1:0] pin_sync
);
    logic [NCH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/irqf_detect.sv
module irqf_detect
    import irqf_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   pin_sync,
    input  logic [2*NCH-1:0] sense,
    output logic [NCH-1:0]   set_vec,
    output logic [NCH-1:0]   level_mode
);
    logic [NCH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= pin_sync;
    end

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            sense_e mode;
            assign mode          = sense_e'(sense[2*n +: 2]);
            assign set_vec[n]    = sense_hit(mode, pin_sync[n], prev_q[n]);
            assign level_mode[n] = is_level(mode);
        end
    endgenerate
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell
    import irqf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set,
    input  logic     ack,
    input  logic     xfer,
    input  logic     xfer_keep,
    input  logic     level_mode,
    input  logic     pin_hi,
    input  bus_evt_t bus,
    input  logic     wr_bit,
    output logic     flag
);
    logic      flag_q;
    logic      armed_q;
    flag_evt_t evt;
    logic      clr;
    logic      flag_d;

    always_comb begin
        evt.set  = set;
        evt.ack  = ack & (~level_mode | pin_hi);
        evt.xfer = xfer & ~xfer_keep;
        evt.sw   = bus.wr_flags & ~wr_bit & armed_q;
        clr      = evt.ack | evt.xfer | evt.sw;
        flag_d   = evt.set | (flag_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (bus.wr_flags)
                armed_q <= 1'b0;
            else if (bus.rd_flags && flag_q)
                armed_q <= 1'b1;
            else
                armed_q <= armed_q & flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
    import irqf_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NCH-1:0]    bus_wdata,
    input  logic [NCH-1:0]    flags,
    output logic [NCH-1:0]    bus_rdata,
    output logic [NCH-1:0]    enable,
    output logic [2*NCH-1:0]  sense,
    output bus_evt_t          bus_evt
);
    localparam int SENSE_REGS = 2;

    logic [NCH-1:0] en_q;
    logic [NCH-1:0] sense_q [SENSE_REGS];

    always_ff @(posedge clk) begin
        if (rst)                              en_q <= '0;
        else if (bus_wr && bus_addr == A_ENABLE) en_q <= bus_wdata;
    end

    generate
        for (genvar k = 0; k < SENSE_REGS; k++) begin : g_sense
            localparam logic [ADDR_W-1:0] MY_ADDR = A_SENSE0 + ADDR_W'(k);
            always_ff @(posedge clk) begin
                if (rst)                              sense_q[k] <= '0;
                else if (bus_wr && bus_addr == MY_ADDR) sense_q[k] <= bus_wdata;
            end
            assign sense[k*NCH +: NCH] = sense_q[k];
        end
    endgenerate

    always_comb begin
        unique case (bus_addr)
            A_FLAGS:  bus_rdata = flags;
            A_ENABLE: bus_rdata = en_q;
            A_SENSE0: bus_rdata = sense_q[0];
            A_SENSE1: bus_rdata = sense_q[1];
            default:  bus_rdata = '0;
        endcase
    end

    assign bus_evt.rd_flags = bus_rd & (bus_addr == A_FLAGS);
    assign bus_evt.wr_flags = bus_wr & (bus_addr == A_FLAGS);
    assign enable           = en_q;
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irqf_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NCH-1:0]    bus_wdata,
    output logic [NCH-1:0]    bus_rdata,
    input  logic [NCH-1:0]    irq_pin,
    input  logic [NCH-1:0]    irq_ack,
    input  logic [NCH-1:0]    xfer_start,
    input  logic              xfer_keep,
    output logic [NCH-1:0]    irq_req
);
    logic [NCH-1:0]   pin_s;
    logic [NCH-1:0]   set_vec;
    logic [NCH-1:0]   level_mode;
    logic [NCH-1:0]   flag_q;
    logic [NCH-1:0]   en_q;
    logic [2*NCH-1:0] sense_q;
    bus_evt_t         bus_evt;

    irqf_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (irq_pin),
        .pin_sync (pin_s)
    );

    irqf_detect #(.NCH(NCH)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .pin_sync   (pin_s),
        .sense      (sense_q),
        .set_vec    (set_vec),
        .level_mode (level_mode)
    );

    irqf_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .flags     (flag_q),
        .bus_rdata (bus_rdata),
        .enable    (en_q),
        .sense     (sense_q),
        .bus_evt   (bus_evt)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_flag
            irqf_flag_cell u_cell (
                .clk        (clk),
                .rst        (rst),
                .set        (set_vec[n]),
                .ack        (irq_ack[n]),
                .xfer       (xfer_start[n]),
                .xfer_keep  (xfer_keep),
                .level_mode (level_mode[n]),
                .pin_hi     (pin_s[n]),
                .bus        (bus_evt),
                .wr_bit     (bus_wdata[n]),
                .flag       (flag_q[n])
            );
        end
    endgenerate

    assign irq_req = flag_q & en_q;
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   flags,
    input logic [NCH-1:0]   set_vec,
    input logic [NCH-1:0]   en,
    input logic [NCH-1:0]   req,
    input logic [NCH-1:0]   ack,
    input logic [NCH-1:0]   xfer,
    input logic [2*NCH-1:0] sense,
    input logic             wr_stat,
    input logic [NCH-1:0]   wdata
);
    logic [NCH-1:0] edge_m;
    always_comb begin
        for (int i = 0; i < NCH; i++) edge_m[i] = |sense[2*i +: 2];
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0));

    p_ones_write_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata == '1 && ack == '0 && xfer == '0)
        |=> (($past(flags) & ~flags) == '0));

    p_clear_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flags) & ~flags & ~$past(ack | xfer | {NCH{wr_stat}})) == '0));

    p_edge_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (|(ack & edge_m & ~set_vec))
        |=> (($past(ack & edge_m & ~set_vec) & flags) == '0));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> (($past(set_vec) & ~flags) == '0));

    p_req_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (req & ~en) == '0);
endmodule

bind irq_flag_unit irqf_checker #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .flags   (flag_q),
    .set_vec (set_vec),
    .en      (en_q),
    .req     (irq_req),
    .ack     (irq_ack),
    .xfer    (xfer_start),
    .sense   (sense_q),
    .wr_stat (bus_evt.wr_flags),
    .wdata   (bus_wdata)
);

// File: tb/irq_flag_unit_test.sv
`timescale 1ns/1ps
module irq_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_pin = 8'hFF;
    logic [7:0] irq_ack = '0;
    logic [7:0] xfer_start = '0;
    logic       xfer_keep = 1'b0;
    logic [7:0] irq_req;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    irq_flag_unit uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin), .irq_ack(irq_ack), .xfer_start(xfer_start),
        .xfer_keep(xfer_keep), .irq_req(irq_req)
    );

    // Monitor: pops expected request vectors and compares them away from the edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (irq_req !== it.exp) begin
                n_fail++;
                $display("FAIL %s irq_req actual=%h expected=%h", it.tag, irq_req, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_req(input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read_check(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        check_val(bus_rdata, exp, tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_ack(input logic [7:0] m);
        irq_ack = m; tick(1); irq_ack = '0;
    endtask

    task automatic pulse_xfer(input logic [7:0] m, input logic keep);
        xfer_start = m; xfer_keep = keep; tick(1); xfer_start = '0; xfer_keep = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        expect_req(8'h00, "R1");
        bus_read_check(2'd0, 8'h00, "R1 flags");
        bus_read_check(2'd1, 8'h00, "R1 enable");
        bus_read_check(2'd2, 8'h00, "R1 sense");

        // R2 configuration: ch0 low, ch1 fall, ch2 rise, ch3 both, ch7..4 fall
        bus_write(2'd1, 8'hFF);
        bus_write(2'd2, 8'hE4);
        bus_write(2'd3, 8'h55);
        bus_read_check(2'd1, 8'hFF, "R2 enable");
        bus_read_check(2'd2, 8'hE4, "R2 sense0");
        bus_read_check(2'd3, 8'h55, "R2 sense1");

        // R12 latency, R3 falling edge
        irq_pin[1] = 1'b0; tick(2);
        expect_req(8'h00, "R12 before third edge");
        tick(1);
        expect_req(8'h02, "R3 falling ch1");
        // R3 rising mode ignores falling, sets on rising
        irq_pin[2] = 1'b0; tick(3);
        expect_req(8'h02, "R3 rise ignores fall");
        irq_pin[2] = 1'b1; tick(3);
        expect_req(8'h06, "R3 rising ch2");
        irq_pin[3] = 1'b0; tick(3);
        expect_req(8'h0E, "R3 both ch3");

        // R5 write ones has no effect
        bus_write(2'd0, 8'hFF);
        expect_req(8'h0E, "R5");
        // R6 zero without prior read has no effect
        bus_write(2'd0, 8'h00);
        expect_req(8'h0E, "R6 no read");
        // R6 read then write zero clears only that bit
        bus_read_check(2'd0, 8'h0E, "R6 read");
        bus_write(2'd0, 8'hFD);
        expect_req(8'h0C, "R6 clear ch1");
        bus_read_check(2'd0, 8'h0C, "R6 read2");
        bus_write(2'd0, 8'h00);
        expect_req(8'h00, "R6 clear rest");

        // R4 level set, R7 level acknowledge
        irq_pin[0] = 1'b0; tick(3);
        expect_req(8'h01, "R4 level set");
        pulse_ack(8'h01);
        expect_req(8'h01, "R7 ack while low keeps");
        irq_pin[0] = 1'b1; tick(3);
        expect_req(8'h01, "R4 flag holds after pin high");
        pulse_ack(8'h01);
        expect_req(8'h00, "R7 ack while high clears");

        // R8 edge acknowledge
        irq_pin[1] = 1'b1; tick(3);
        expect_req(8'h00, "R3 fall mode ignores rise");
        irq_pin[1] = 1'b0; tick(3);
        expect_req(8'h02, "R3 fall ch1 again");
        pulse_ack(8'h02);
        expect_req(8'h00, "R8 edge ack clears");

        // R9 transfer start with keep input
        irq_pin[4] = 1'b0; tick(3);
        expect_req(8'h10, "R3 fall ch4");
        pulse_xfer(8'h10, 1'b1);
        expect_req(8'h10, "R9 keep=1 holds");
        pulse_xfer(8'h10, 1'b0);
        expect_req(8'h00, "R9 keep=0 clears");

        // R10 set wins over a same-cycle acknowledge
        irq_pin[5] = 1'b0; tick(2);
        pulse_ack(8'h20);
        expect_req(8'h20, "R10 set wins");
        pulse_ack(8'h20);
        expect_req(8'h00, "R8 ack ch5");

        // R11 enable masking
        bus_write(2'd1, 8'hBF);
        irq_pin[6] = 1'b0; tick(3);
        expect_req(8'h00, "R11 masked");
        bus_read_check(2'd0, 8'h40, "R11 flag readable");
        // R6 an intervening write cancels the qualification
        bus_write(2'd0, 8'hFF);
        bus_write(2'd0, 8'h00);
        bus_read_check(2'd0, 8'h40, "R6 disarmed by write");
        bus_write(2'd1, 8'hFF);
        expect_req(8'h40, "R11 unmasked");
        bus_write(2'd0, 8'hBF);
        expect_req(8'h00, "R6 clear ch6");

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule